// File: doc/BRIEF.md
# SMBus Target Transaction Decoder

This block sits between a byte-level I2C target engine and a register back end. The engine reports bus activity as single-cycle strobes: a start addressed for writing, a start addressed for reading, a stop, a NACK from the master, each received byte, and each request for a byte to transmit. The decoder collects written bytes in a local buffer. It decides which SMBus operation took place only when the transaction closes, and it reports that operation to the back end as a one-cycle dispatch strobe.

The operation is chosen from the number of buffered bytes when a stop or a repeated start arrives. A write with no bytes is a quick command. A write with one byte is a send-byte. Anything longer is a command byte followed by payload. Reads are served through a request/valid handshake with the back end, and the returned byte is registered before it goes back to the I2C engine. Any event that does not fit the current mode puts the block into an error mode. The block stays there until the next stop.

Top module: `smbus_txn_decoder`

## Requirements
- R1: After reset the block is idle. `err`, `ovf`, every dispatch strobe, `be_req` and `rbyte_valid` are low.
- R2: A write start while idle begins buffering received bytes. A write start in any other mode raises `err` in the next cycle.
- R3: A stop after a write with zero buffered bytes pulses `disp_quick` for one cycle, starting the cycle after the stop, with `disp_quick_rd` = 0. At most one dispatch strobe is high in any cycle.
- R4: A stop after a write with exactly one buffered byte pulses `disp_send` in the next cycle, and `disp_cmd` carries that byte.
- R5: A stop after a write with n ≥ 2 buffered bytes pulses `disp_write` in the next cycle. `disp_cmd` is the first byte and `disp_len` = n−1. Payload byte k (k = 1..n−1) is at `disp_data[8k+7:8k]`.
- R6: A stop during a read that began from idle pulses `disp_quick` with `disp_quick_rd` = 1. Every stop returns the block to idle with a zero byte count.
- R7: A repeated read start after a write behaves by buffered count. With zero bytes it raises `err`. With one byte it latches that byte as the command and dispatches nothing. With n ≥ 2 bytes it dispatches the write as in R5. In both non-error cases the count is cleared and the block enters sequential read.
- R8: A byte request in a read that began from idle raises `be_req` in the same cycle with `be_kind` = 0. The block then treats any further byte request as an error, and a NACK there is ignored. `rbyte_valid` pulses with `rbyte_data` = `be_data` in the cycle after `be_valid`.
- R9: A byte request in sequential read raises `be_req` with `be_kind` = 1, `be_cmd` = the latched command and `be_off` = the current count. The count then increments, so successive requests use offsets 0, 1, 2 and so on.
- R10: A NACK in sequential read ends the read. A further NACK is ignored. A NACK while idle or buffering raises `err`.
- R11: A byte request while idle, buffering, finished or in error leaves `be_req` low. It pulses `rbyte_valid` in the next cycle with `rbyte_data` = 0 and raises `err`.
- R12: A received byte outside buffering changes neither the buffer count nor the read offset.
- R13: The buffer holds DEPTH (34) bytes. A byte that arrives when the buffer is full is dropped and sets `ovf`. `ovf` stays set until the next write start from idle.
- R14: `err` stays high from entry into the error mode until a stop, and the stop clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start_wr | input | 1 | Start or repeated start addressed for writing |
| ev_start_rd | input | 1 | Start or repeated start addressed for reading |
| ev_stop | input | 1 | Stop condition |
| ev_nack | input | 1 | Master did not acknowledge a byte |
| ev_wbyte | input | 1 | A byte was received from the master |
| wbyte_data | input | 8 | Received byte |
| ev_rreq | input | 1 | Engine needs a byte to transmit |
| rbyte_valid | output | 1 | Byte to transmit is ready |
| rbyte_data | output | 8 | Byte to transmit |
| be_req | output | 1 | Read request to the back end |
| be_kind | output | 1 | 0 = single receive byte, 1 = command-indexed read |
| be_cmd | output | 8 | Latched command for indexed reads |
| be_off | output | CW | Byte offset within the indexed read |
| be_valid | input | 1 | Back end returns a byte |
| be_data | input | 8 | Byte returned by the back end |
| disp_quick | output | 1 | Quick command strobe |
| disp_quick_rd | output | 1 | Direction of the quick command (1 = read) |
| disp_send | output | 1 | Send-byte strobe |
| disp_write | output | 1 | Command-plus-payload write strobe |
| disp_cmd | output | 8 | Command or sent byte |
| disp_len | output | CW | Payload length |
| disp_data | output | DEPTH*8 | Buffer contents, byte k at bits 8k+7:8k |
| ovf | output | 1 | Buffer overflow flag |
| err | output | 1 | Error mode indicator |

## Verification
On every cycle the assertions check these rules:
- dispatch strobes are mutually exclusive, and a payload write never has zero length;
- any stop leaves the block idle with a zero count;
- the error mode persists until a stop;
- a push into a full buffer sets the overflow flag without moving the count;
- a back-end byte always turns into a transmit byte one cycle later.

The following can only be shown by the bench's scenarios, because each one needs a whole transaction to build up context:
- choosing the operation from the buffered count;
- latching the command on a repeated start;
- the rising offsets of a sequential read;
- received bytes being ignored outside buffering;
- the exact payload placement at the 34-byte limit.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    typedef enum logic [2:0] {
        M_IDLE   = 3'd0,
        M_WDATA  = 3'd1,
        M_RXBYTE = 3'd2,
        M_RDATA  = 3'd3,
        M_DONE   = 3'd4,
        M_CONF   = 3'd5
    } mode_e;

    typedef enum logic {
        BE_RX_BYTE   = 1'b0,
        BE_READ_DATA = 1'b1
    } be_kind_e;

endpackage

// File: rtl/smbt_wbuf.sv
module smbt_wbuf #(
    parameter int DEPTH = 34,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic [7:0]           push_data,
    input  logic                 clr,
    input  logic                 inc,
    input  logic                 ovf_clr,
    output logic [CW-1:0]        count,
    output logic                 full,
    output logic                 ovf,
    output logic [DEPTH*8-1:0]   buf_flat
);

    typedef struct packed {
        logic [CW-1:0]           count;
        logic                    ovf;
        logic [DEPTH-1:0][7:0]   mem;
    } wb_t;

    wb_t s_d, s_q;

    assign full     = (s_q.count >= CW'(DEPTH));
    assign count    = s_q.count;
    assign ovf      = s_q.ovf;
    assign buf_flat = s_q.mem;

    always_comb begin
        s_d = s_q;
        if (ovf_clr) begin
            s_d.ovf = 1'b0;
        end
        if (clr) begin
            s_d.count = '0;
        end else if (inc) begin
            s_d.count = s_q.count + 1'b1;
        end else if (push) begin
            if (!full) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (s_q.count == CW'(i)) begin
                        s_d.mem[i] = push_data;
                    end
                end
                s_d.count = s_q.count + 1'b1;
            end else begin
                s_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !clr && !inc && !ovf_clr) |=> (ovf && $stable(count))); // R13

endmodule

// File: rtl/smbt_rdpath.sv
module smbt_rdpath (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch,
    input  logic       zero_rsp,
    input  logic       be_valid,
    input  logic [7:0] be_data,
    output logic       rbyte_valid,
    output logic [7:0] rbyte_data,
    output logic       pending
);

    typedef struct packed {
        logic       pend;
        logic       vld;
        logic [7:0] data;
    } rp_t;

    rp_t s_d, s_q;

    assign rbyte_valid = s_q.vld;
    assign rbyte_data  = s_q.data;
    assign pending     = s_q.pend;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (zero_rsp) begin
            s_d.vld  = 1'b1;
            s_d.data = 8'h00;
        end else if (s_q.pend && be_valid) begin
            s_d.vld  = 1'b1;
            s_d.data = be_data;
            s_d.pend = 1'b0;
        end
        if (fetch) begin
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && be_valid && !zero_rsp) |=> (rbyte_valid && rbyte_data == $past(be_data))); // R8

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |-> !pending); // R8

endmodule

// File: rtl/smbus_txn_decoder.sv
module smbus_txn_decoder
    import smbt_pkg::*;
#(
    parameter int DEPTH = 34,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_start_wr,
    input  logic                 ev_start_rd,
    input  logic                 ev_stop,
    input  logic                 ev_nack,
    input  logic                 ev_wbyte,
    input  logic [7:0]           wbyte_data,
    input  logic                 ev_rreq,
    output logic                 rbyte_valid,
    output logic [7:0]           rbyte_data,
    output logic                 be_req,
    output logic                 be_kind,
    output logic [7:0]           be_cmd,
    output logic [CW-1:0]        be_off,
    input  logic                 be_valid,
    input  logic [7:0]           be_data,
    output logic                 disp_quick,
    output logic                 disp_quick_rd,
    output logic                 disp_send,
    output logic                 disp_write,
    output logic [7:0]           disp_cmd,
    output logic [CW-1:0]        disp_len,
    output logic [DEPTH*8-1:0]   disp_data,
    output logic                 ovf,
    output logic                 err
);

    typedef struct packed {
        mode_e          mode;
        logic [7:0]     cmd;
        logic           quick;
        logic           quick_rd;
        logic           send;
        logic           write;
        logic [7:0]     dcmd;
        logic [CW-1:0]  dlen;
    } st_t;

    st_t s_d, s_q;

    logic           wb_push, wb_clr, wb_inc, wb_ovf_clr, wb_full;
    logic [CW-1:0]  wb_count;
    logic [DEPTH*8-1:0] wb_flat;
    logic           rd_fetch, rd_zero, rd_pending;
    be_kind_e       kind_c;
    logic [7:0]     first_b;

    assign first_b = wb_flat[7:0];

    smbt_wbuf #(.DEPTH(DEPTH), .CW(CW)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wb_push),
        .push_data (wbyte_data),
        .clr       (wb_clr),
        .inc       (wb_inc),
        .ovf_clr   (wb_ovf_clr),
        .count     (wb_count),
        .full      (wb_full),
        .ovf       (ovf),
        .buf_flat  (wb_flat)
    );

    smbt_rdpath u_rdpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch       (rd_fetch),
        .zero_rsp    (rd_zero),
        .be_valid    (be_valid),
        .be_data     (be_data),
        .rbyte_valid (rbyte_valid),
        .rbyte_data  (rbyte_data),
        .pending     (rd_pending)
    );

    always_comb begin
        s_d          = s_q;
        s_d.quick    = 1'b0;
        s_d.quick_rd = 1'b0;
        s_d.send     = 1'b0;
        s_d.write    = 1'b0;
        wb_push      = 1'b0;
        wb_clr       = 1'b0;
        wb_inc       = 1'b0;
        wb_ovf_clr   = 1'b0;
        rd_fetch     = 1'b0;
        rd_zero      = 1'b0;
        kind_c       = BE_RX_BYTE;

        if (ev_stop) begin
            unique case (s_q.mode)
                M_WDATA: begin
                    if (wb_count == '0) begin
                        s_d.quick = 1'b1;
                    end else if (wb_count == CW'(1)) begin
                        s_d.send = 1'b1;
                        s_d.dcmd = first_b;
                    end else begin
                        s_d.write = 1'b1;
                        s_d.dcmd  = first_b;
                        s_d.dlen  = wb_count - 1'b1;
                    end
                end
                M_RXBYTE: begin
                    s_d.quick    = 1'b1;
                    s_d.quick_rd = 1'b1;
                end
                default: ;
            endcase
            s_d.mode = M_IDLE;
            wb_clr   = 1'b1;
        end else if (ev_start_wr) begin
            if (s_q.mode == M_IDLE) begin
                s_d.mode   = M_WDATA;
                wb_ovf_clr = 1'b1;
            end else begin
                s_d.mode = M_CONF;
            end
        end else if (ev_start_rd) begin
            unique case (s_q.mode)
                M_IDLE:  s_d.mode = M_RXBYTE;
                M_WDATA: begin
                    if (wb_count == '0) begin
                        s_d.mode = M_CONF;
                    end else begin
                        s_d.cmd = first_b;
                        if (wb_count > CW'(1)) begin
                            s_d.write = 1'b1;
                            s_d.dcmd  = first_b;
                            s_d.dlen  = wb_count - 1'b1;
                        end
                        wb_clr   = 1'b1;
                        s_d.mode = M_RDATA;
                    end
                end
                default: s_d.mode = M_CONF;
            endcase
        end else if (ev_nack) begin
            unique case (s_q.mode)
                M_RDATA: s_d.mode = M_DONE;
                M_DONE:  ;
                default: s_d.mode = M_CONF;
            endcase
        end else if (ev_rreq) begin
            unique case (s_q.mode)
                M_RXBYTE: begin
                    rd_fetch = 1'b1;
                    kind_c   = BE_RX_BYTE;
                    s_d.mode = M_DONE;
                end
                M_RDATA: begin
                    rd_fetch = 1'b1;
                    kind_c   = BE_READ_DATA;
                    wb_inc   = 1'b1;
                end
                default: begin
                    rd_zero  = 1'b1;
                    s_d.mode = M_CONF;
                end
            endcase
        end else if (ev_wbyte) begin
            if (s_q.mode == M_WDATA) begin
                wb_push = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: M_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign be_req        = rd_fetch;
    assign be_kind       = kind_c;
    assign be_cmd        = s_q.cmd;
    assign be_off        = wb_count;
    assign disp_quick    = s_q.quick;
    assign disp_quick_rd = s_q.quick_rd;
    assign disp_send     = s_q.send;
    assign disp_write    = s_q.write;
    assign disp_cmd      = s_q.dcmd;
    assign disp_len      = s_q.dlen;
    assign disp_data     = wb_flat;
    assign err           = (s_q.mode == M_CONF);

    AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({disp_quick, disp_send, disp_write})); // R3

    AST_WRITE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        disp_write |-> (disp_len != '0)); // R5

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (s_q.mode == M_IDLE && wb_count == '0)); // R6

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !ev_stop) |=> err); // R14

    AST_NACK_END: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nack && !ev_stop && !ev_start_wr && !ev_start_rd && s_q.mode == M_RDATA)
        |=> (s_q.mode == M_DONE)); // R10

    AST_REQ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && be_kind) |=> (wb_count == $past(be_off) + 1'b1)); // R9

endmodule

// File: tb/tb_smbus_txn_decoder.sv
module tb_smbus_txn_decoder;

    localparam int DEPTH = 34;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start_wr = 0, ev_start_rd = 0, ev_stop = 0, ev_nack = 0;
    logic ev_wbyte = 0, ev_rreq = 0, be_valid = 0;
    logic [7:0] wbyte_data = 0, be_data = 0;
    logic rbyte_valid, be_req, be_kind, disp_quick, disp_quick_rd;
    logic disp_send, disp_write, ovf, err;
    logic [7:0] rbyte_data, be_cmd, disp_cmd;
    logic [CW-1:0] be_off, disp_len;
    logic [DEPTH*8-1:0] disp_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic       snap_req, snap_kind;
    logic [7:0] snap_cmd;
    logic [CW-1:0] snap_off;

    always #4 clk = ~clk;

    smbus_txn_decoder #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .ev_start_wr(ev_start_wr), .ev_start_rd(ev_start_rd), .ev_stop(ev_stop),
        .ev_nack(ev_nack), .ev_wbyte(ev_wbyte), .wbyte_data(wbyte_data),
        .ev_rreq(ev_rreq), .rbyte_valid(rbyte_valid), .rbyte_data(rbyte_data),
        .be_req(be_req), .be_kind(be_kind), .be_cmd(be_cmd), .be_off(be_off),
        .be_valid(be_valid), .be_data(be_data),
        .disp_quick(disp_quick), .disp_quick_rd(disp_quick_rd), .disp_send(disp_send),
        .disp_write(disp_write), .disp_cmd(disp_cmd), .disp_len(disp_len),
        .disp_data(disp_data), .ovf(ovf), .err(err)
    );

    localparam int NV = 6;
    localparam int          VEC_N    [NV] = '{0, 1, 2, 3, 5, 4};
    localparam logic [7:0]  VEC_SEED [NV] = '{8'h10, 8'h4C, 8'h80, 8'hC3, 8'h05, 8'hF0};
    localparam int          VEC_KIND [NV] = '{0, 1, 2, 2, 2, 2};
    localparam int          VEC_LEN  [NV] = '{0, 0, 1, 2, 4, 3};

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // kinds: 0 start_wr, 1 start_rd, 2 stop, 3 nack, 4 wbyte, 5 rreq
    task automatic ev(input int which, input logic [7:0] d);
        @(negedge clk);
        case (which)
            0: ev_start_wr = 1;
            1: ev_start_rd = 1;
            2: ev_stop     = 1;
            3: ev_nack     = 1;
            4: begin ev_wbyte = 1; wbyte_data = d; end
            default: ev_rreq = 1;
        endcase
        #1;
        snap_req = be_req; snap_kind = be_kind; snap_cmd = be_cmd; snap_off = be_off;
        @(negedge clk);
        ev_start_wr = 0; ev_start_rd = 0; ev_stop = 0; ev_nack = 0;
        ev_wbyte = 0; ev_rreq = 0;
    endtask

    task automatic respond(input logic [7:0] d);
        @(negedge clk);
        be_valid = 1; be_data = d;
        @(negedge clk);
        be_valid = 0;
    endtask

    function automatic logic [7:0] pbyte(input int k);
        return disp_data[8*k +: 8];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 err", err, 0);
        check("R1 ovf", ovf, 0);
        check("R1 strobes", {disp_quick, disp_send, disp_write}, 0);
        check("R1 be_req/rbyte_valid", {be_req, rbyte_valid}, 0);

        // Table of write transactions: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            ev(0, 0);
            for (int i = 0; i < VEC_N[v]; i++) ev(4, VEC_SEED[v] + 8'(i));
            ev(2, 0);
            check("R3 quick", disp_quick, VEC_KIND[v] == 0);
            check("R3 quick dir", disp_quick_rd, 0);
            check("R4 send", disp_send, VEC_KIND[v] == 1);
            check("R5 write", disp_write, VEC_KIND[v] == 2);
            if (VEC_N[v] >= 1) check("R4 cmd", disp_cmd, VEC_SEED[v]);
            if (VEC_KIND[v] == 2) begin
                check("R5 len", disp_len, VEC_LEN[v]);
                for (int k = 1; k <= VEC_LEN[v]; k++)
                    check("R5 payload", pbyte(k), VEC_SEED[v] + 8'(k));
            end
            check("R2 no err", err, 0);
        end

        // R6: quick read
        ev(1, 0); ev(2, 0);
        check("R6 quick rd", {disp_quick, disp_quick_rd}, 2'b11);

        // R8: receive byte
        ev(1, 0); ev(5, 0);
        check("R8 be_req", snap_req, 1);
        check("R8 be_kind", snap_kind, 0);
        respond(8'h5A);
        check("R8 rbyte_valid", rbyte_valid, 1);
        check("R8 rbyte_data", rbyte_data, 8'h5A);
        ev(3, 0);
        check("R8 nack ignored", err, 0);
        ev(2, 0);
        check("R6 no dispatch after read", {disp_quick, disp_send, disp_write}, 0);

        // R7 one byte + R9 sequential offsets + R10 nack + R12 byte ignored
        ev(0, 0); ev(4, 8'h21); ev(1, 0);
        check("R7 no dispatch", {disp_quick, disp_send, disp_write}, 0);
        ev(4, 8'h99); // R12 ignored in read
        for (int r = 0; r < 3; r++) begin
            ev(5, 0);
            check("R9 be_req", snap_req, 1);
            check("R9 be_kind", snap_kind, 1);
            check("R9 be_cmd", snap_cmd, 8'h21);
            check("R9 R12 be_off", snap_off, r);
            respond(8'h21 + 8'(r));
            check("R9 rbyte", {rbyte_valid, rbyte_data}, {1'b1, 8'h21 + 8'(r)});
        end
        ev(3, 0);
        check("R10 nack to done", err, 0);
        ev(3, 0);
        check("R10 second nack ignored", err, 0);
        ev(2, 0);

        // R7 multi byte: dispatch write then read
        ev(0, 0); ev(4, 8'h30); ev(4, 8'h31); ev(4, 8'h32); ev(1, 0);
        check("R7 write dispatch", disp_write, 1);
        check("R7 cmd", disp_cmd, 8'h30);
        check("R7 len", disp_len, 2);
        ev(5, 0);
        check("R7 offset cleared", snap_off, 0);
        check("R7 cmd latched", snap_cmd, 8'h30);
        respond(8'h77);
        ev(2, 0);

        // R7 zero bytes -> error; R14 sticky; R2 start_wr in error
        ev(0, 0); ev(1, 0);
        check("R7 zero err", err, 1);
        ev(0, 0);
        check("R14 err held", err, 1);
        ev(2, 0);
        check("R14 stop clears", err, 0);

        // R2 start_wr while buffering
        ev(0, 0); ev(0, 0);
        check("R2 start_wr err", err, 1);
        ev(2, 0);

        // R10 nack in idle
        ev(3, 0);
        check("R10 nack idle err", err, 1);
        ev(2, 0);

        // R11 byte request while idle
        ev(5, 0);
        check("R11 no be_req", snap_req, 0);
        check("R11 zero byte", {rbyte_valid, rbyte_data}, 9'h100);
        check("R11 err", err, 1);
        ev(2, 0);

        // R12 byte in idle ignored
        ev(4, 8'hEE); ev(0, 0); ev(2, 0);
        check("R12 idle byte ignored", disp_quick, 1);

        // R13 overflow
        ev(0, 0);
        for (int i = 0; i < DEPTH; i++) ev(4, 8'h40 + 8'(i));
        check("R13 no ovf at full", ovf, 0);
        ev(4, 8'hAA);
        check("R13 ovf set", ovf, 1);
        ev(2, 0);
        check("R13 len", disp_len, DEPTH - 1);
        check("R13 last byte kept", pbyte(DEPTH - 1), 8'h40 + 8'(DEPTH - 1));
        check("R13 ovf held", ovf, 1);
        ev(0, 0);
        check("R13 ovf cleared", ovf, 0);
        ev(2, 0);

        finish_run();
    end

endmodule